// File: doc/BRIEF.md
# Addressable Serial Frame Receiver

This block is the receive half of an asynchronous serial port. It oversamples the incoming line with a 16x baud tick, confirms each start bit at its midpoint, and collects 7, 8 or 9 data bits (least significant first), an optional parity bit and one or two stop bits into a shift register. When the last stop bit has been sampled, the frame moves into a holding buffer. Every status flag (buffer full, overrun, framing, parity and an OR of the three errors) is written at that moment and no other, and an interrupt pulse marks the buffer going from empty to full.

On a line shared by several nodes, a sleep control lets the node drop every frame whose top data bit is 0. Address frames carry a 1 in that bit and still arrive, so software can compare the lower bits with its own address and decide whether to leave sleep. An optional active-low ready-to-send output drops low while the shift register is idle and can take a new frame.

Top module: `uart_sleep_rx`

## Requirements
- R1: A frame is a start bit (0), data bits least significant first, an optional parity bit, then stop bits. On completion the buffer `rx_data` holds the data, and bits above the frame length read 0.
- R2: `rx_full` goes to 1 when a frame enters the buffer. `rx_irq` is a one-cycle pulse in the cycle `rx_full` first shows 1 after being 0, and it does not pulse on a transfer into a buffer that is already full.
- R3: A transfer while `rx_full` is 1 sets `err_ovr` and replaces the buffer contents with the new frame.
- R4: `err_frm` is set when any configured stop bit is sampled as 0. `two_stop`=1 selects two stop bits and 0 selects one.
- R5: `par_mode` 2'b01 selects even parity, 2'b10 odd parity, and 2'b00 or 2'b11 no parity bit. A mismatch sets `err_par`. Without parity `err_par` is never set.
- R6: `err_sum` equals the OR of `err_ovr`, `err_frm` and `err_par` whenever those flags are written.
- R7: All flags change only at a transfer. They all clear on the clock edge after `rd_lo` is high or `rx_en` is low. A transfer in the same cycle as `rd_lo` wins, and the buffer data is kept on a clear.
- R8: With `sleep_en`=1, a frame whose most significant data bit is 0 is dropped. That bit is bit 6, 7 or 8 for 7-, 8- or 9-bit frames. When a frame is dropped, the buffer, the flags and `rx_irq` stay unchanged.
- R9: With `sleep_en`=1, a frame whose most significant data bit is 1 is received exactly as with sleep off.
- R10: With `rts_en`=1 and `rx_en`=1, `rts_n` is 0 while the receiver is idle and 1 from start-bit detection until the frame ends. It is 1 whenever `rx_en` or `rts_en` is 0.
- R11: A low pulse that reads high at the start bit's midpoint is a false start. It is ignored, and the receiver returns to idle with no transfer.
- R12: `len_sel` selects the data length: 2'b00 gives 7 bits, 2'b01 gives 8 bits, 2'b10 gives 9 bits, and 2'b11 gives 8 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial receive line, idle high |
| tick16 | input | 1 | One-cycle pulse at 16 times the baud rate |
| rx_en | input | 1 | Receive enable; low clears flags and idles receiver |
| sleep_en | input | 1 | Drop frames whose top data bit is 0 |
| rts_en | input | 1 | Enable the ready-to-send output |
| len_sel | input | 2 | Data length select |
| par_mode | input | 2 | Parity mode select |
| two_stop | input | 1 | Two stop bits when 1 |
| rd_lo | input | 1 | Buffer low-byte read strobe; clears flags |
| rx_data | output | 9 | Receive buffer |
| rx_full | output | 1 | Buffer holds unread data |
| err_ovr | output | 1 | Overrun error |
| err_frm | output | 1 | Framing error |
| err_par | output | 1 | Parity error |
| err_sum | output | 1 | OR of the error flags |
| rx_irq | output | 1 | Receive interrupt pulse |
| rts_n | output | 1 | Ready to send, active low |

## Verification
The checker watches the rules that hold on every cycle. The error summary always agrees with the three error flags. Flags and buffer hold still between transfers unless a clear happens. An interrupt pulse only comes with a fresh empty-to-full change. A transfer beats a coincident read, a disable clears everything on the next edge, and a frame dropped in sleep leaves the buffer alone. The receive scenarios in the bench are the only place that shows the bit-level work: the data assembled for each length setting, the parity polarity, stop-bit counting, which bit the sleep filter inspects, the rejection of a false start, and the timing of the ready-to-send output within a frame.

// File: rtl/usr_pkg.sv
package usr_pkg;
  localparam int unsigned OSR      = 16;
  localparam int unsigned MAX_BITS = 9;
  localparam int unsigned CNT_W    = $clog2(OSR);
  localparam int unsigned IDX_W    = $clog2(MAX_BITS + 1);

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } rx_state_e;

  typedef enum logic [1:0] {
    PM_NONE  = 2'b00,
    PM_EVEN  = 2'b01,
    PM_ODD   = 2'b10,
    PM_NONE2 = 2'b11
  } par_mode_e;

  function automatic logic [IDX_W-1:0] frame_len(input logic [1:0] sel);
    case (sel)
      2'b00:   frame_len = IDX_W'(7);
      2'b10:   frame_len = IDX_W'(9);
      default: frame_len = IDX_W'(8);
    endcase
  endfunction

  function automatic logic parity_on(input logic [1:0] pm);
    parity_on = (pm == PM_EVEN) || (pm == PM_ODD);
  endfunction
endpackage

// File: rtl/usr_sync.sv
module usr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= d_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/usr_bit_fsm.sv
module usr_bit_fsm
  import usr_pkg::*;
#(
  parameter int unsigned OVERSAMPLE = OSR,
  parameter int unsigned NBITS_MAX  = MAX_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line_s,
  input  logic                 tick16,
  input  logic                 rx_en,
  input  logic [1:0]           len_sel,
  input  logic [1:0]           par_mode,
  input  logic                 two_stop,
  output logic                 frame_vld,
  output logic [NBITS_MAX-1:0] frame_data,
  output logic                 frame_par_bit,
  output logic                 frame_stop_bad,
  output logic                 busy
);
  localparam int unsigned CW   = $clog2(OVERSAMPLE);
  localparam int unsigned IW   = $clog2(NBITS_MAX + 1);
  localparam logic [CW-1:0] LAST = CW'(OVERSAMPLE - 1);
  localparam logic [CW-1:0] MID  = CW'(OVERSAMPLE / 2 - 1);

  rx_state_e             st_q, st_n;
  logic [CW-1:0]         cnt_q, cnt_n;
  logic [IW-1:0]         idx_q, idx_n;
  logic [NBITS_MAX-1:0]  sh_q, sh_n;
  logic                  pb_q, pb_n;
  logic                  sbad_q, sbad_n;
  logic                  sidx_q, sidx_n;
  logic                  vld_q, vld_n;
  logic [IW-1:0]         nbits;

  assign nbits = IW'(frame_len(len_sel));

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    idx_n  = idx_q;
    sh_n   = sh_q;
    pb_n   = pb_q;
    sbad_n = sbad_q;
    sidx_n = sidx_q;
    vld_n  = 1'b0;
    if (!rx_en) begin
      st_n = ST_IDLE;
    end else if (tick16) begin
      case (st_q)
        ST_IDLE: begin
          if (!line_s) begin
            st_n  = ST_START;
            cnt_n = '0;
          end
        end
        ST_START: begin
          cnt_n = cnt_q + 1'b1;
          if (cnt_q == MID) begin
            if (!line_s) begin
              st_n   = ST_DATA;
              cnt_n  = '0;
              idx_n  = '0;
              sh_n   = '0;
              sbad_n = 1'b0;
              pb_n   = 1'b0;
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        ST_DATA: begin
          cnt_n = cnt_q + 1'b1;
          if (cnt_q == LAST) begin
            sh_n[idx_q] = line_s;
            if (idx_q == nbits - 1'b1) begin
              sidx_n = 1'b0;
              st_n   = parity_on(par_mode) ? ST_PAR : ST_STOP;
            end else begin
              idx_n = idx_q + 1'b1;
            end
          end
        end
        ST_PAR: begin
          cnt_n = cnt_q + 1'b1;
          if (cnt_q == LAST) begin
            pb_n   = line_s;
            sidx_n = 1'b0;
            st_n   = ST_STOP;
          end
        end
        ST_STOP: begin
          cnt_n = cnt_q + 1'b1;
          if (cnt_q == LAST) begin
            if (!line_s) sbad_n = 1'b1;
            if (two_stop && !sidx_q) begin
              sidx_n = 1'b1;
            end else begin
              vld_n = 1'b1;
              st_n  = ST_IDLE;
            end
          end
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      pb_q   <= 1'b0;
      sbad_q <= 1'b0;
      sidx_q <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      idx_q  <= idx_n;
      sh_q   <= sh_n;
      pb_q   <= pb_n;
      sbad_q <= sbad_n;
      sidx_q <= sidx_n;
      vld_q  <= vld_n;
    end
  end

  assign frame_vld      = vld_q;
  assign frame_data     = sh_q;
  assign frame_par_bit  = pb_q;
  assign frame_stop_bad = sbad_q;
  assign busy           = (st_q != ST_IDLE);
endmodule

// File: rtl/usr_frame_eval.sv
module usr_frame_eval
  import usr_pkg::*;
#(
  parameter int unsigned NBITS_MAX = MAX_BITS
) (
  input  logic [NBITS_MAX-1:0] data,
  input  logic                 par_bit,
  input  logic [1:0]           len_sel,
  input  logic [1:0]           par_mode,
  output logic                 par_err,
  output logic                 top_bit
);
  localparam int unsigned IW = $clog2(NBITS_MAX + 1);
  logic [IW-1:0] nbits;
  logic          ones_odd;

  assign nbits    = IW'(frame_len(len_sel));
  assign ones_odd = ^data;

  always_comb begin
    case (par_mode)
      PM_EVEN: par_err = ones_odd ^ par_bit;
      PM_ODD:  par_err = ~(ones_odd ^ par_bit);
      default: par_err = 1'b0;
    endcase
  end

  assign top_bit = data[nbits - 1'b1];
endmodule

// File: rtl/usr_rx_status.sv
module usr_rx_status #(
  parameter int unsigned NBITS_MAX = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 xfer,
  input  logic                 clr,
  input  logic [NBITS_MAX-1:0] data_in,
  input  logic                 frm_in,
  input  logic                 par_in,
  output logic [NBITS_MAX-1:0] buf_q,
  output logic                 full_q,
  output logic                 ovr_q,
  output logic                 frm_q,
  output logic                 par_q,
  output logic                 sum_q,
  output logic                 irq_q
);
  logic                 buf_en;
  logic [NBITS_MAX-1:0] buf_n;
  logic full_n, ovr_n, frm_n, par_n, sum_n, irq_n;

  always_comb begin
    buf_en = xfer;
    buf_n  = data_in;
    full_n = full_q;
    ovr_n  = ovr_q;
    frm_n  = frm_q;
    par_n  = par_q;
    sum_n  = sum_q;
    irq_n  = 1'b0;
    if (xfer) begin
      full_n = 1'b1;
      ovr_n  = full_q;
      frm_n  = frm_in;
      par_n  = par_in;
      sum_n  = full_q | frm_in | par_in;
      irq_n  = ~full_q;
    end else if (clr) begin
      full_n = 1'b0;
      ovr_n  = 1'b0;
      frm_n  = 1'b0;
      par_n  = 1'b0;
      sum_n  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
    end else if (buf_en) begin
      buf_q <= buf_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      frm_q  <= 1'b0;
      par_q  <= 1'b0;
      sum_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      full_q <= full_n;
      ovr_q  <= ovr_n;
      frm_q  <= frm_n;
      par_q  <= par_n;
      sum_q  <= sum_n;
      irq_q  <= irq_n;
    end
  end
endmodule

// File: rtl/uart_sleep_rx.sv
module uart_sleep_rx
  import usr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned NBITS_MAX   = MAX_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rxd,
  input  logic                 tick16,
  input  logic                 rx_en,
  input  logic                 sleep_en,
  input  logic                 rts_en,
  input  logic [1:0]           len_sel,
  input  logic [1:0]           par_mode,
  input  logic                 two_stop,
  input  logic                 rd_lo,
  output logic [NBITS_MAX-1:0] rx_data,
  output logic                 rx_full,
  output logic                 err_ovr,
  output logic                 err_frm,
  output logic                 err_par,
  output logic                 err_sum,
  output logic                 rx_irq,
  output logic                 rts_n
);
  logic                 line_s;
  logic                 frame_vld;
  logic [NBITS_MAX-1:0] frame_data;
  logic                 frame_par_bit;
  logic                 frame_stop_bad;
  logic                 busy;
  logic                 par_err;
  logic                 frame_msb;
  logic                 xfer_go;
  logic                 clr_go;

  usr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (rxd),
    .d_out (line_s)
  );

  usr_bit_fsm #(.OVERSAMPLE(OSR), .NBITS_MAX(NBITS_MAX)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .line_s         (line_s),
    .tick16         (tick16),
    .rx_en          (rx_en),
    .len_sel        (len_sel),
    .par_mode       (par_mode),
    .two_stop       (two_stop),
    .frame_vld      (frame_vld),
    .frame_data     (frame_data),
    .frame_par_bit  (frame_par_bit),
    .frame_stop_bad (frame_stop_bad),
    .busy           (busy)
  );

  usr_frame_eval #(.NBITS_MAX(NBITS_MAX)) u_eval (
    .data     (frame_data),
    .par_bit  (frame_par_bit),
    .len_sel  (len_sel),
    .par_mode (par_mode),
    .par_err  (par_err),
    .top_bit  (frame_msb)
  );

  assign xfer_go = frame_vld && rx_en && !(sleep_en && !frame_msb);
  assign clr_go  = rd_lo || !rx_en;

  usr_rx_status #(.NBITS_MAX(NBITS_MAX)) u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .xfer    (xfer_go),
    .clr     (clr_go),
    .data_in (frame_data),
    .frm_in  (frame_stop_bad),
    .par_in  (par_err),
    .buf_q   (rx_data),
    .full_q  (rx_full),
    .ovr_q   (err_ovr),
    .frm_q   (err_frm),
    .par_q   (err_par),
    .sum_q   (err_sum),
    .irq_q   (rx_irq)
  );

  assign rts_n = !(rts_en && rx_en && !busy);
endmodule

// File: rtl/usr_checker.sv
module usr_checker #(
  parameter int unsigned NBITS_MAX = 9
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rx_en,
  input logic                 rts_en,
  input logic                 rd_lo,
  input logic                 sleep_en,
  input logic                 frame_vld,
  input logic                 frame_msb,
  input logic                 xfer_go,
  input logic [NBITS_MAX-1:0] rx_data,
  input logic                 rx_full,
  input logic                 err_ovr,
  input logic                 err_frm,
  input logic                 err_par,
  input logic                 err_sum,
  input logic                 rx_irq,
  input logic                 rts_n
);
  a_r6_sum_matches: assert property (@(posedge clk) disable iff (!rst_n)
    err_sum == (err_ovr | err_frm | err_par));

  a_r2_irq_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> (rx_full && !$past(rx_full)));

  a_r2_rise_gives_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !$past(rx_full)) |-> rx_irq);

  a_r7_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!rx_full && !err_sum && !err_ovr && !err_frm && !err_par));

  a_r7_xfer_wins: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_go |=> rx_full);

  a_r7_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_go && !rd_lo && rx_en) |=>
      $stable({rx_data, rx_full, err_ovr, err_frm, err_par, err_sum}));

  a_r8_sleep_keeps_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_vld && sleep_en && !frame_msb) |=> ($stable(rx_data) && !rx_irq));

  a_r10_rts_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en || !rts_en) |-> rts_n);
endmodule

bind uart_sleep_rx usr_checker #(.NBITS_MAX(NBITS_MAX)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_en     (rx_en),
  .rts_en    (rts_en),
  .rd_lo     (rd_lo),
  .sleep_en  (sleep_en),
  .frame_vld (frame_vld),
  .frame_msb (frame_msb),
  .xfer_go   (xfer_go),
  .rx_data   (rx_data),
  .rx_full   (rx_full),
  .err_ovr   (err_ovr),
  .err_frm   (err_frm),
  .err_par   (err_par),
  .err_sum   (err_sum),
  .rx_irq    (rx_irq),
  .rts_n     (rts_n)
);

// File: tb/uart_sleep_rx_tb.sv
module uart_sleep_rx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int BIT_CLKS   = 16 * TICK_DIV;
  localparam int WATCHDOG   = 150000;

  typedef struct {
    logic [8:0] data;
    logic       ovr;
    logic       frm;
    logic       par;
    string      tag;
  } exp_t;

  logic clk, rst_n, rxd, tick16, rx_en, sleep_en, rts_en, two_stop, rd_lo;
  logic [1:0] len_sel, par_mode;
  logic [8:0] rx_data;
  logic rx_full, err_ovr, err_frm, err_par, err_sum, rx_irq, rts_n;

  int n_checks = 0;
  int n_fail   = 0;
  int irq_seen = 0;
  int tick_cnt = 0;
  bit done     = 0;
  exp_t sb_q[$];

  uart_sleep_rx u_dut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .tick16(tick16), .rx_en(rx_en),
    .sleep_en(sleep_en), .rts_en(rts_en), .len_sel(len_sel),
    .par_mode(par_mode), .two_stop(two_stop), .rd_lo(rd_lo),
    .rx_data(rx_data), .rx_full(rx_full), .err_ovr(err_ovr),
    .err_frm(err_frm), .err_par(err_par), .err_sum(err_sum),
    .rx_irq(rx_irq), .rts_n(rts_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    tick_cnt = (tick_cnt == TICK_DIV - 1) ? 0 : tick_cnt + 1;
    tick16  <= (tick_cnt == 0);
  end

  task automatic check(input string tag, input int actual, input int expected);
    n_checks++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, actual, expected);
    end
  endtask

  // Monitor: pop one expected frame per interrupt pulse
  initial begin
    forever begin
      @(negedge clk);
      if (rx_irq) begin
        irq_seen++;
        if (sb_q.size() == 0) begin
          check("R2/R8 unexpected irq", 1, 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check({e.tag, " data"}, int'(rx_data), int'(e.data));
          check({e.tag, " ovr R3"}, int'(err_ovr), int'(e.ovr));
          check({e.tag, " frm R4"}, int'(err_frm), int'(e.frm));
          check({e.tag, " par R5"}, int'(err_par), int'(e.par));
          check({e.tag, " sum R6"}, int'(err_sum), int'(e.ovr | e.frm | e.par));
        end
      end
    end
  end

  task automatic hold_bit(input logic v);
    rxd = v;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  // Driver: send one frame, pushing an expectation when a transfer is due
  task automatic send(input logic [8:0] d, input int nb, input bit flip,
                      input bit st2_low, input bit want, input bit ovr,
                      input string tag);
    logic pbit;
    logic [8:0] dm;
    bit par_en;
    dm = d & 9'((1 << nb) - 1);
    par_en = (par_mode == 2'b01) || (par_mode == 2'b10);
    pbit = (^dm) ^ (par_mode == 2'b10) ^ flip;
    if (want) begin
      exp_t e;
      e.data = dm; e.ovr = ovr; e.frm = two_stop && st2_low;
      e.par = par_en && flip; e.tag = tag;
      sb_q.push_back(e);
    end
    @(negedge clk);
    rxd = 1'b0;
    repeat (BIT_CLKS) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      rxd = dm[i];
      repeat (BIT_CLKS/2) @(negedge clk);
      if (i == 0 && rts_en) check({tag, " R10 rts busy"}, int'(rts_n), 1);
      repeat (BIT_CLKS - BIT_CLKS/2) @(negedge clk);
    end
    if (par_en) hold_bit(pbit);
    hold_bit(1'b1);
    if (two_stop) hold_bit(!st2_low);
    hold_bit(1'b1);
    repeat (4) @(negedge clk);
  endtask

  task automatic read_buf();
    @(negedge clk); rd_lo = 1'b1;
    @(negedge clk); rd_lo = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(negedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int irq_before;
    rst_n = 1'b0; rxd = 1'b1; rx_en = 1'b0; sleep_en = 1'b0; rts_en = 1'b1;
    len_sel = 2'b01; par_mode = 2'b00; two_stop = 1'b0; rd_lo = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R2 reset full", int'(rx_full), 0);
    check("R6 reset sum", int'(err_sum), 0);
    check("R2 reset irq", int'(rx_irq), 0);
    check("R10 rts off when disabled", int'(rts_n), 1);
    rx_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 rts low when idle", int'(rts_n), 0);

    // R1 8-bit clean frame
    send(9'h0A5, 8, 0, 0, 1, 0, "R1 8bit");
    check("R2 full after frame", int'(rx_full), 1);
    read_buf(); @(negedge clk);
    check("R7 read clears full", int'(rx_full), 0);
    check("R7 read keeps data", int'(rx_data), 'h0A5);

    // R12 7-bit, R5 even parity good
    len_sel = 2'b00; par_mode = 2'b01;
    send(9'h035, 7, 0, 0, 1, 0, "R12 7bit even");
    read_buf();

    // R5 odd parity wrong in 9-bit frame
    len_sel = 2'b10; par_mode = 2'b10;
    send(9'h1C3, 9, 1, 0, 1, 0, "R5 9bit odd bad");
    read_buf(); @(negedge clk);
    check("R7 read clears par", int'(err_par), 0);
    check("R6 read clears sum", int'(err_sum), 0);

    // R4 second stop bit low
    len_sel = 2'b01; par_mode = 2'b00; two_stop = 1'b1;
    send(9'h03C, 8, 0, 1, 1, 0, "R4 two stop bad");
    read_buf();
    two_stop = 1'b0;
    repeat (2 * BIT_CLKS) @(negedge clk);

    // R3 overrun, R2 no irq on second transfer
    send(9'h011, 8, 0, 0, 1, 0, "R3 first");
    irq_before = irq_seen;
    send(9'h022, 8, 0, 0, 0, 0, "R3 second");
    check("R2 no irq while full", irq_seen, irq_before);
    check("R3 data overwritten", int'(rx_data), 'h022);
    check("R3 ovr set", int'(err_ovr), 1);
    check("R6 sum on ovr", int'(err_sum), 1);
    read_buf();

    // R8 sleep drop 8-bit, R9 address accepted
    sleep_en = 1'b1;
    send(9'h07F, 8, 0, 0, 0, 0, "R8 drop8");
    check("R8 full unchanged", int'(rx_full), 0);
    check("R8 data unchanged", int'(rx_data), 'h022);
    send(9'h081, 8, 0, 0, 1, 0, "R9 addr8");
    read_buf();
    // R8 9-bit: bit 8 is the inspected bit
    len_sel = 2'b10;
    send(9'h0FF, 9, 0, 0, 0, 0, "R8 drop9");
    check("R8 9bit data unchanged", int'(rx_data), 'h081);
    check("R8 9bit full unchanged", int'(rx_full), 0);
    send(9'h100, 9, 0, 0, 1, 0, "R9 addr9");
    read_buf();
    sleep_en = 1'b0;

    // R12 encoding 11 -> 8 bits, R5 no parity never errs
    len_sel = 2'b11; par_mode = 2'b11;
    send(9'h0C3, 8, 0, 0, 1, 0, "R12 len11");
    read_buf();
    len_sel = 2'b01; par_mode = 2'b00;

    // R11 false start
    @(negedge clk); rxd = 1'b0;
    repeat (2 * TICK_DIV) @(negedge clk);
    check("R10 rts high at start", int'(rts_n), 1);
    rxd = 1'b1;
    repeat (BIT_CLKS) @(negedge clk);
    check("R11 false start no data", int'(rx_full), 0);
    check("R11 rts back low", int'(rts_n), 0);

    // R7 disable clears
    send(9'h055, 8, 0, 0, 1, 0, "R7 pre-disable");
    rx_en = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R7 disable clears full", int'(rx_full), 0);
    check("R10 rts high disabled", int'(rts_n), 1);
    rx_en = 1'b1;
    repeat (4) @(negedge clk);

    check("R2 scoreboard drained", sb_q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule